// File: doc/BRIEF.md
# Per-Master Bus Access Hit Filter

This block sits beside the access ports of several bus masters (by default one processor port and four DMA channels) and decides, for every access, whether it is worth recording. Each master lane presents a valid flag, a read/write flag, a size code, an address and a data word. When an access passes every qualification test, the block raises a one-cycle hit pulse on that master's output lane. The pulse carries a record of the access so that a separate log writer can store it. This block does not store anything itself.

Software-style configuration arrives as plain inputs:
- a 4-bit mode field that selects write-only filtering and which access sizes count;
- one enable bit per master;
- a shared pair of address bounds;
- a compare word with a byte-ignore mask.

Each master keeps its own private address window. The shared bounds reach a window only when that master's load strobe pulses, or when the broadcast load strobe pulses. Several masters can therefore watch different ranges while using one pair of bound inputs.

Top module: `bus_hit_filter`

## Requirements
- R1: After synchronous reset, `hit_valid` is all zero and every master's window is [0, 0], so an enabled master hits at address 0 but not at address 4.
- R2: A master whose `cfg_master_en` bit is 0 never produces a hit, while other enabled masters are unaffected.
- R3: Size codes are 00 = byte, 01 = halfword, 10 = word and 11 = reserved. `cfg_mode` bit 3 admits byte accesses, bit 2 admits halfword accesses and bit 1 admits word accesses. Size 11 never qualifies.
- R4: When `cfg_mode` bit 0 is 1, only writes (`acc_write` = 1) qualify. When it is 0, both reads and writes qualify.
- R5: An address qualifies when lo <= addr <= hi against that master's window. Both bounds are inclusive.
- R6: Pulsing `win_load[m]` copies `cfg_win_lo`/`cfg_win_hi` into master m's window only. Changing the bound inputs without a strobe leaves every window unchanged.
- R7: Pulsing `win_load_all` copies the bounds into every master's window in one cycle.
- R8: Data qualifies when every byte i (bits 8i+7..8i) either equals the same byte of `cfg_cmp_data` or has `cfg_byte_ign[i]` = 1. Bit 0 of the mask covers the least significant byte.
- R9: A hit is registered. It appears in the cycle after the access and carries the master index, size, address and data of that access. An access presented in the same cycle as a load strobe is judged against the old window.
- R10: Lanes are independent. Simultaneous accesses on several masters each produce their own hit or miss in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 4 | bit0 write-only, bit1 word, bit2 halfword, bit3 byte |
| cfg_master_en | input | NUM_MASTERS | Per-master logging enable |
| cfg_win_lo | input | ADDR_W | Shared lower bound (inclusive) |
| cfg_win_hi | input | ADDR_W | Shared upper bound (inclusive) |
| cfg_cmp_data | input | DATA_W | Compare word |
| cfg_byte_ign | input | DATA_W/8 | 1 = ignore that byte in the compare |
| win_load | input | NUM_MASTERS | Per-master window load strobe |
| win_load_all | input | 1 | Broadcast window load strobe |
| acc_valid | input | NUM_MASTERS | Access present on lane |
| acc_write | input | NUM_MASTERS | 1 = write, 0 = read |
| acc_size | input | 2*NUM_MASTERS | Size code per lane |
| acc_addr | input | ADDR_W*NUM_MASTERS | Address per lane |
| acc_data | input | DATA_W*NUM_MASTERS | Data per lane |
| hit_valid | output | NUM_MASTERS | One-cycle hit pulse per lane |
| hit_id | output | ID_W*NUM_MASTERS | Master index of the record |
| hit_size | output | 2*NUM_MASTERS | Size of the recorded access |
| hit_addr | output | ADDR_W*NUM_MASTERS | Address of the recorded access |
| hit_data | output | DATA_W*NUM_MASTERS | Data of the recorded access |

## Verification
The hardest case to reach from the ports is a window load strobe that lands in the same cycle as an access to the affected master. Here the hit must follow the window that was in force before the load. The bench pulses the strobe together with an access that only the old window covers. In the next cycles it probes both the old range and the new range. Per-master isolation needs similar care. A strobe for one master is followed by a probe on a different master at the newly loaded address. The bound inputs are then moved without any strobe and the old range is probed again.

// File: rtl/bus_hit_filter_pkg.sv
package bus_hit_filter_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_RSVD = 2'b11
    } acc_size_e;

    localparam int MODE_WR_ONLY = 0;
    localparam int MODE_WORD    = 1;
    localparam int MODE_HALF    = 2;
    localparam int MODE_BYTE    = 3;

    function automatic logic size_allowed(input logic [3:0] mode, input logic [1:0] size);
        logic ok;
        case (acc_size_e'(size))
            SZ_BYTE: ok = mode[MODE_BYTE];
            SZ_HALF: ok = mode[MODE_HALF];
            SZ_WORD: ok = mode[MODE_WORD];
            default: ok = 1'b0;
        endcase
        return ok;
    endfunction

    function automatic logic type_allowed(input logic [3:0] mode, input logic is_write);
        return !mode[MODE_WR_ONLY] || is_write;
    endfunction

endpackage

// File: rtl/hf_window_bank.sv
module hf_window_bank #(
    parameter int NUM_MASTERS = 5,
    parameter int ADDR_W      = 32
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [ADDR_W-1:0]             bound_lo,
    input  logic [ADDR_W-1:0]             bound_hi,
    input  logic [NUM_MASTERS-1:0]        load_one,
    input  logic                          load_all,
    output logic [ADDR_W*NUM_MASTERS-1:0] win_lo_flat,
    output logic [ADDR_W*NUM_MASTERS-1:0] win_hi_flat
);

    for (genvar m = 0; m < NUM_MASTERS; m++) begin : g_win
        logic [ADDR_W-1:0] lo_q;
        logic [ADDR_W-1:0] hi_q;
        logic              take;

        assign take = load_one[m] | load_all;

        always_ff @(posedge clk) begin
            if (rst) begin
                lo_q <= '0;
                hi_q <= '0;
            end else if (take) begin
                lo_q <= bound_lo;
                hi_q <= bound_hi;
            end
        end

        assign win_lo_flat[m*ADDR_W +: ADDR_W] = lo_q;
        assign win_hi_flat[m*ADDR_W +: ADDR_W] = hi_q;
    end

endmodule

// File: rtl/hf_lane_qualify.sv
module hf_lane_qualify
    import bus_hit_filter_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic                enable,
    input  logic [3:0]          mode,
    input  logic [DATA_W-1:0]   cmp_data,
    input  logic [DATA_W/8-1:0] byte_ign,
    input  logic [ADDR_W-1:0]   win_lo,
    input  logic [ADDR_W-1:0]   win_hi,
    input  logic                valid,
    input  logic                is_write,
    input  logic [1:0]          size,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   data,
    output logic                qualify
);

    localparam int NBYTES = DATA_W / 8;

    logic [NBYTES-1:0] byte_ok;
    logic              size_ok;
    logic              type_ok;
    logic              addr_ok;
    logic              data_ok;

    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        assign byte_ok[b] = byte_ign[b] | (data[8*b +: 8] == cmp_data[8*b +: 8]);
    end

    always_comb begin
        size_ok = size_allowed(mode, size);
        type_ok = type_allowed(mode, is_write);
        addr_ok = (addr >= win_lo) && (addr <= win_hi);
        data_ok = &byte_ok;
        qualify = valid & enable & size_ok & type_ok & addr_ok & data_ok;
    end

endmodule

// File: rtl/hf_hit_stage.sv
module hf_hit_stage #(
    parameter int NUM_MASTERS = 5,
    parameter int ADDR_W      = 32,
    parameter int DATA_W      = 32,
    parameter int ID_W        = 3
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [NUM_MASTERS-1:0]        qualify,
    input  logic [2*NUM_MASTERS-1:0]      in_size,
    input  logic [ADDR_W*NUM_MASTERS-1:0] in_addr,
    input  logic [DATA_W*NUM_MASTERS-1:0] in_data,
    output logic [NUM_MASTERS-1:0]        hit_valid,
    output logic [ID_W*NUM_MASTERS-1:0]   hit_id,
    output logic [2*NUM_MASTERS-1:0]      hit_size,
    output logic [ADDR_W*NUM_MASTERS-1:0] hit_addr,
    output logic [DATA_W*NUM_MASTERS-1:0] hit_data
);

    for (genvar m = 0; m < NUM_MASTERS; m++) begin : g_rec
        localparam logic [ID_W-1:0] LANE_ID = ID_W'(m);

        always_ff @(posedge clk) begin
            if (rst) begin
                hit_valid[m]                  <= 1'b0;
                hit_id[m*ID_W +: ID_W]        <= '0;
                hit_size[m*2 +: 2]            <= '0;
                hit_addr[m*ADDR_W +: ADDR_W]  <= '0;
                hit_data[m*DATA_W +: DATA_W]  <= '0;
            end else begin
                hit_valid[m] <= qualify[m];
                if (qualify[m]) begin
                    hit_id[m*ID_W +: ID_W]       <= LANE_ID;
                    hit_size[m*2 +: 2]           <= in_size[m*2 +: 2];
                    hit_addr[m*ADDR_W +: ADDR_W] <= in_addr[m*ADDR_W +: ADDR_W];
                    hit_data[m*DATA_W +: DATA_W] <= in_data[m*DATA_W +: DATA_W];
                end
            end
        end
    end

endmodule

// File: rtl/bus_hit_filter.sv
module bus_hit_filter #(
    parameter int NUM_MASTERS = 5,
    parameter int ADDR_W      = 32,
    parameter int DATA_W      = 32,
    localparam int ID_W       = (NUM_MASTERS > 1) ? $clog2(NUM_MASTERS) : 1,
    localparam int NBYTES     = DATA_W / 8
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [3:0]                    cfg_mode,
    input  logic [NUM_MASTERS-1:0]        cfg_master_en,
    input  logic [ADDR_W-1:0]             cfg_win_lo,
    input  logic [ADDR_W-1:0]             cfg_win_hi,
    input  logic [DATA_W-1:0]             cfg_cmp_data,
    input  logic [NBYTES-1:0]             cfg_byte_ign,
    input  logic [NUM_MASTERS-1:0]        win_load,
    input  logic                          win_load_all,
    input  logic [NUM_MASTERS-1:0]        acc_valid,
    input  logic [NUM_MASTERS-1:0]        acc_write,
    input  logic [2*NUM_MASTERS-1:0]      acc_size,
    input  logic [ADDR_W*NUM_MASTERS-1:0] acc_addr,
    input  logic [DATA_W*NUM_MASTERS-1:0] acc_data,
    output logic [NUM_MASTERS-1:0]        hit_valid,
    output logic [ID_W*NUM_MASTERS-1:0]   hit_id,
    output logic [2*NUM_MASTERS-1:0]      hit_size,
    output logic [ADDR_W*NUM_MASTERS-1:0] hit_addr,
    output logic [DATA_W*NUM_MASTERS-1:0] hit_data
);

    logic [ADDR_W*NUM_MASTERS-1:0] win_lo_flat;
    logic [ADDR_W*NUM_MASTERS-1:0] win_hi_flat;
    logic [NUM_MASTERS-1:0]        lane_qual;

    hf_window_bank #(
        .NUM_MASTERS (NUM_MASTERS),
        .ADDR_W      (ADDR_W)
    ) u_windows (
        .clk         (clk),
        .rst         (rst),
        .bound_lo    (cfg_win_lo),
        .bound_hi    (cfg_win_hi),
        .load_one    (win_load),
        .load_all    (win_load_all),
        .win_lo_flat (win_lo_flat),
        .win_hi_flat (win_hi_flat)
    );

    for (genvar m = 0; m < NUM_MASTERS; m++) begin : g_lane
        hf_lane_qualify #(
            .ADDR_W (ADDR_W),
            .DATA_W (DATA_W)
        ) u_qual (
            .enable   (cfg_master_en[m]),
            .mode     (cfg_mode),
            .cmp_data (cfg_cmp_data),
            .byte_ign (cfg_byte_ign),
            .win_lo   (win_lo_flat[m*ADDR_W +: ADDR_W]),
            .win_hi   (win_hi_flat[m*ADDR_W +: ADDR_W]),
            .valid    (acc_valid[m]),
            .is_write (acc_write[m]),
            .size     (acc_size[m*2 +: 2]),
            .addr     (acc_addr[m*ADDR_W +: ADDR_W]),
            .data     (acc_data[m*DATA_W +: DATA_W]),
            .qualify  (lane_qual[m])
        );
    end

    hf_hit_stage #(
        .NUM_MASTERS (NUM_MASTERS),
        .ADDR_W      (ADDR_W),
        .DATA_W      (DATA_W),
        .ID_W        (ID_W)
    ) u_hits (
        .clk       (clk),
        .rst       (rst),
        .qualify   (lane_qual),
        .in_size   (acc_size),
        .in_addr   (acc_addr),
        .in_data   (acc_data),
        .hit_valid (hit_valid),
        .hit_id    (hit_id),
        .hit_size  (hit_size),
        .hit_addr  (hit_addr),
        .hit_data  (hit_data)
    );

endmodule

// File: rtl/bus_hit_filter_chk.sv
module bus_hit_filter_chk
    import bus_hit_filter_pkg::*;
#(
    parameter int NUM_MASTERS = 5,
    parameter int ADDR_W      = 32,
    parameter int DATA_W      = 32,
    parameter int ID_W        = 3
) (
    input logic                          clk,
    input logic                          rst,
    input logic [3:0]                    cfg_mode,
    input logic [NUM_MASTERS-1:0]        cfg_master_en,
    input logic [DATA_W-1:0]             cfg_cmp_data,
    input logic [DATA_W/8-1:0]           cfg_byte_ign,
    input logic [NUM_MASTERS-1:0]        acc_valid,
    input logic [NUM_MASTERS-1:0]        acc_write,
    input logic [2*NUM_MASTERS-1:0]      acc_size,
    input logic [ADDR_W*NUM_MASTERS-1:0] acc_addr,
    input logic [DATA_W*NUM_MASTERS-1:0] acc_data,
    input logic [NUM_MASTERS-1:0]        hit_valid,
    input logic [ID_W*NUM_MASTERS-1:0]   hit_id,
    input logic [2*NUM_MASTERS-1:0]      hit_size,
    input logic [ADDR_W*NUM_MASTERS-1:0] hit_addr,
    input logic [DATA_W*NUM_MASTERS-1:0] hit_data
);

    localparam int NBYTES = DATA_W / 8;

    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(rst) |-> hit_valid == '0);  // R1

    for (genvar m = 0; m < NUM_MASTERS; m++) begin : g_chk
        AST_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
            hit_valid[m] |-> $past(cfg_master_en[m]) && $past(acc_valid[m]));  // R2

        AST_SIZE_SELECT: assert property (@(posedge clk) disable iff (rst)
            hit_valid[m] |-> size_allowed($past(cfg_mode), hit_size[m*2 +: 2]));  // R3

        AST_WRITE_ONLY: assert property (@(posedge clk) disable iff (rst)
            (hit_valid[m] && $past(cfg_mode[MODE_WR_ONLY])) |-> $past(acc_write[m]));  // R4

        AST_RECORD_ECHO: assert property (@(posedge clk) disable iff (rst)
            hit_valid[m] |-> (hit_addr[m*ADDR_W +: ADDR_W] == $past(acc_addr[m*ADDR_W +: ADDR_W]))
                          && (hit_data[m*DATA_W +: DATA_W] == $past(acc_data[m*DATA_W +: DATA_W]))
                          && (hit_id[m*ID_W +: ID_W] == ID_W'(m)));  // R9

        for (genvar b = 0; b < NBYTES; b++) begin : g_byte
            AST_DATA_MATCH: assert property (@(posedge clk) disable iff (rst)
                (hit_valid[m] && !$past(cfg_byte_ign[b]))
                    |-> hit_data[m*DATA_W + 8*b +: 8] == $past(cfg_cmp_data[8*b +: 8]));  // R8
        end
    end

endmodule

bind bus_hit_filter bus_hit_filter_chk #(
    .NUM_MASTERS (NUM_MASTERS),
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .ID_W        (ID_W)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .cfg_mode      (cfg_mode),
    .cfg_master_en (cfg_master_en),
    .cfg_cmp_data  (cfg_cmp_data),
    .cfg_byte_ign  (cfg_byte_ign),
    .acc_valid     (acc_valid),
    .acc_write     (acc_write),
    .acc_size      (acc_size),
    .acc_addr      (acc_addr),
    .acc_data      (acc_data),
    .hit_valid     (hit_valid),
    .hit_id        (hit_id),
    .hit_size      (hit_size),
    .hit_addr      (hit_addr),
    .hit_data      (hit_data)
);

// File: tb/bus_hit_filter_bench.sv
`timescale 1ns/1ps
module bus_hit_filter_bench;

    localparam int NM   = 5;
    localparam int AW   = 32;
    localparam int DW   = 32;
    localparam int IDW  = 3;
    localparam int NVEC = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [3:0]        cfg_mode = '0;
    logic [NM-1:0]     cfg_master_en = '0;
    logic [AW-1:0]     cfg_win_lo = '0;
    logic [AW-1:0]     cfg_win_hi = '0;
    logic [DW-1:0]     cfg_cmp_data = '0;
    logic [DW/8-1:0]   cfg_byte_ign = '0;
    logic [NM-1:0]     win_load = '0;
    logic              win_load_all = 1'b0;
    logic [NM-1:0]     acc_valid = '0;
    logic [NM-1:0]     acc_write = '0;
    logic [2*NM-1:0]   acc_size = '0;
    logic [AW*NM-1:0]  acc_addr = '0;
    logic [DW*NM-1:0]  acc_data = '0;
    logic [NM-1:0]     hit_valid;
    logic [IDW*NM-1:0] hit_id;
    logic [2*NM-1:0]   hit_size;
    logic [AW*NM-1:0]  hit_addr;
    logic [DW*NM-1:0]  hit_data;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    bus_hit_filter u_bus_hit_filter (
        .clk, .rst, .cfg_mode, .cfg_master_en, .cfg_win_lo, .cfg_win_hi,
        .cfg_cmp_data, .cfg_byte_ign, .win_load, .win_load_all,
        .acc_valid, .acc_write, .acc_size, .acc_addr, .acc_data,
        .hit_valid, .hit_id, .hit_size, .hit_addr, .hit_data
    );

    // {write, size[1:0], addr[31:0], data[31:0], expect_hit}
    // window [0x1000,0x1FFF], mode 1110, compare A5xxxxCC (bytes 1,2 ignored)
    localparam logic [67:0] VEC [NVEC] = '{
        {1'b0, 2'b10, 32'h0000_1000, 32'hA512_34CC, 1'b1},  // R5 lower bound
        {1'b1, 2'b01, 32'h0000_1FFF, 32'hA5FF_FFCC, 1'b1},  // R5 upper bound
        {1'b0, 2'b00, 32'h0000_0FFF, 32'hA500_00CC, 1'b0},  // R5 below
        {1'b1, 2'b10, 32'h0000_2000, 32'hA500_00CC, 1'b0},  // R5 above
        {1'b0, 2'b10, 32'h0000_1800, 32'hA512_34CD, 1'b0},  // R8 byte0 differs
        {1'b0, 2'b10, 32'h0000_1800, 32'hA412_34CC, 1'b0},  // R8 byte3 differs
        {1'b1, 2'b11, 32'h0000_1800, 32'hA512_34CC, 1'b0},  // R3 reserved size
        {1'b1, 2'b00, 32'h0000_1800, 32'hA500_00CC, 1'b1}   // R8 ignored bytes
    };

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clear_inputs();
        acc_valid = '0; acc_write = '0; win_load = '0; win_load_all = 1'b0;
    endtask

    task automatic set_lane(input int m, input bit wr, input logic [1:0] sz,
                            input logic [31:0] a, input logic [31:0] d);
        acc_valid[m]        = 1'b1;
        acc_write[m]        = wr;
        acc_size[m*2 +: 2]  = sz;
        acc_addr[m*AW +: AW] = a;
        acc_data[m*DW +: DW] = d;
    endtask

    task automatic settle();
        @(posedge clk); #1;
    endtask

    task automatic expect_lane(input int m, input bit exp, input string req);
        check(hit_valid[m] == exp, req, 32'(hit_valid[m]), 32'(exp));
        if (exp && hit_valid[m]) begin
            check(hit_addr[m*AW +: AW] == acc_addr[m*AW +: AW], {req, " addr"},
                  hit_addr[m*AW +: AW], acc_addr[m*AW +: AW]);
            check(hit_data[m*DW +: DW] == acc_data[m*DW +: DW], {req, " data"},
                  hit_data[m*DW +: DW], acc_data[m*DW +: DW]);
            check(hit_size[m*2 +: 2] == acc_size[m*2 +: 2], {req, " size"},
                  32'(hit_size[m*2 +: 2]), 32'(acc_size[m*2 +: 2]));
            check(hit_id[m*IDW +: IDW] == IDW'(m), {req, " id"},
                  32'(hit_id[m*IDW +: IDW]), m);
        end
    endtask

    task automatic single(input int m, input bit wr, input logic [1:0] sz,
                          input logic [31:0] a, input logic [31:0] d,
                          input bit exp, input string req);
        @(negedge clk); clear_inputs(); set_lane(m, wr, sz, a, d);
        settle();
        expect_lane(m, exp, req);
    endtask

    task automatic load(input int m, input bit all, input logic [31:0] lo, input logic [31:0] hi);
        @(negedge clk); clear_inputs();
        cfg_win_lo = lo; cfg_win_hi = hi;
        if (all) win_load_all = 1'b1; else win_load[m] = 1'b1;
        settle();
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 150000);
        failures++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check(hit_valid == '0, "R1 reset quiet", 32'(hit_valid), 0);
        @(negedge clk); rst = 1'b0;

        // R1: windows come out of reset as [0,0]
        cfg_mode = 4'b1110; cfg_byte_ign = 4'hF; cfg_master_en = 5'b00010;
        single(1, 0, 2'b10, 32'h4, 32'h0, 0, "R1 reset window excludes 4");
        single(1, 0, 2'b10, 32'h0, 32'h0, 1, "R1 reset window holds 0");

        // Table on master 0
        cfg_master_en = 5'b00001;
        cfg_cmp_data = 32'hA5A5_00CC; cfg_byte_ign = 4'b0110;
        load(0, 0, 32'h1000, 32'h1FFF);
        for (int i = 0; i < NVEC; i++) begin
            single(0, VEC[i][67], VEC[i][66:65], VEC[i][64:33], VEC[i][32:1],
                   VEC[i][0], $sformatf("R5/R8/R3 vector %0d", i));
        end

        // R6: per-master load touches only that master
        cfg_master_en = 5'b00011;
        single(1, 0, 2'b10, 32'h1000, 32'hA500_00CC, 0, "R6 other master untouched");
        @(negedge clk); clear_inputs(); cfg_win_lo = 32'h3000; cfg_win_hi = 32'h3FFF;
        single(0, 0, 2'b10, 32'h1000, 32'hA500_00CC, 1, "R6 bounds without strobe keep window");
        single(0, 0, 2'b10, 32'h3000, 32'hA500_00CC, 0, "R6 new bounds not yet loaded");

        // R9: strobe in the same cycle as the access uses old window
        @(negedge clk); clear_inputs(); win_load[0] = 1'b1;
        set_lane(0, 0, 2'b10, 32'h1000, 32'hA500_00CC);
        settle();
        expect_lane(0, 1, "R9 same-cycle strobe uses old window");
        single(0, 0, 2'b10, 32'h1000, 32'hA500_00CC, 0, "R9 old window gone");
        single(0, 0, 2'b10, 32'h3FFF, 32'hA500_00CC, 1, "R9 new window active");

        // R7 broadcast + R10 lane independence
        cfg_master_en = 5'b11111;
        load(0, 1, 32'h8000, 32'h80FF);
        @(negedge clk); clear_inputs();
        for (int m = 0; m < NM; m++) set_lane(m, m[0], 2'b10, 32'h8080 + m, 32'hA500_00CC);
        acc_data[2*DW +: DW] = 32'h0000_00CC;
        settle();
        for (int m = 0; m < NM; m++) expect_lane(m, m != 2, "R7 broadcast / R10 independent lanes");

        // R2: disabled master silent, neighbour still hits
        cfg_master_en = 5'b10111;
        @(negedge clk); clear_inputs();
        set_lane(3, 1, 2'b10, 32'h8000, 32'hA500_00CC);
        set_lane(4, 1, 2'b10, 32'h80FF, 32'hA500_00CC);
        settle();
        expect_lane(3, 0, "R2 disabled master");
        expect_lane(4, 1, "R2 enabled neighbour");

        // R3: size selection
        cfg_mode = 4'b1100;
        single(4, 0, 2'b10, 32'h8000, 32'hA500_00CC, 0, "R3 word disabled");
        single(4, 0, 2'b01, 32'h8000, 32'hA500_00CC, 1, "R3 half enabled");
        single(4, 0, 2'b00, 32'h8000, 32'hA500_00CC, 1, "R3 byte enabled");
        cfg_mode = 4'b0010;
        single(4, 0, 2'b00, 32'h8000, 32'hA500_00CC, 0, "R3 byte disabled");
        single(4, 0, 2'b01, 32'h8000, 32'hA500_00CC, 0, "R3 half disabled");
        single(4, 0, 2'b10, 32'h8000, 32'hA500_00CC, 1, "R3 word only");

        // R4: write-only filtering
        cfg_mode = 4'b1111;
        single(4, 0, 2'b10, 32'h8000, 32'hA500_00CC, 0, "R4 read rejected");
        single(4, 1, 2'b10, 32'h8000, 32'hA500_00CC, 1, "R4 write accepted");

        // R8: full mask accepts any data
        cfg_byte_ign = 4'hF;
        single(4, 1, 2'b10, 32'h8001, 32'h1234_5678, 1, "R8 all bytes ignored");

        // R9: pulse lasts one cycle
        @(negedge clk); clear_inputs();
        settle();
        check(hit_valid == '0, "R9 single-cycle pulse", 32'(hit_valid), 0);

        // R1: reset clears a pending hit
        @(negedge clk); clear_inputs(); set_lane(4, 1, 2'b10, 32'h8000, 32'h0);
        settle();
        @(negedge clk); clear_inputs(); rst = 1'b1;
        settle();
        check(hit_valid == '0, "R1 reset clears hit", 32'(hit_valid), 0);
        @(negedge clk); rst = 1'b0;
        single(4, 1, 2'b10, 32'h8000, 32'h0, 0, "R1 window reset after rerun");

        finish_run();
    end

endmodule